// File: doc/BRIEF.md
# Indirect Jump Target Predictor

This block predicts where a jump-register instruction will go in a core that runs several hardware threads. A single shared table holds full target addresses, one per entry, each with a valid bit. An entry is chosen by XORing word-address bits of the jump PC with a short history of recent indirect targets. Each thread keeps its own history register, selected by a thread ID, so one thread's jumps never disturb the hash of another thread. The table itself is shared by all threads.

The front end issues a lookup with a thread ID and a PC. One cycle later the block returns a predicted target and a flag that says whether the prediction is usable. When a jump resolves, the back end sends an update with the thread ID, the PC and the real target. The block writes the target into the entry chosen by the thread's current history and marks that entry valid. It then folds two bits of the target into that thread's history.

Top module: `jump_target_predictor`

## Requirements
- R1: While reset is asserted and after it is released, `pred_vld` is 0. Every table entry is invalid and every thread history is zero.
- R2: A lookup presented in one cycle produces its result on `pred_vld`/`pred_target` after the next rising edge. In a cycle after one with `lk_en` low, `pred_vld` is 0.
- R3: The entry used by a lookup is `lk_pc[11:2] XOR H`, where H is the 10-bit history of thread `lk_tid`.
- R4: An update writes `up_target` into entry `up_pc[11:2] XOR H` (H being the history of `up_tid`) and marks it valid. A later lookup that maps to that entry returns `pred_vld`=1 and that exact target. A lookup that maps to an invalid entry returns `pred_vld`=0.
- R5: An update changes the history of thread `up_tid` to `((H << 2) XOR up_target[3:2])`, truncated to 10 bits.
- R6: An update leaves the histories of all other threads unchanged.
- R7: When a lookup and an update arrive in the same cycle, the lookup sees the table and histories as they were before that update.
- R8: PC bits outside [11:2] have no effect on the entry chosen. Two PCs that differ only there share an entry.
- R9: The table is shared. An update from any thread overwrites whatever another thread left in the entry it selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_en | input | 1 | Lookup request this cycle |
| lk_tid | input | 2 | Thread of the lookup |
| lk_pc | input | 32 | PC of the jump being looked up |
| pred_vld | output | 1 | Prediction is usable (registered) |
| pred_target | output | 32 | Predicted target address (registered) |
| up_en | input | 1 | Update request this cycle |
| up_tid | input | 2 | Thread of the resolved jump |
| up_pc | input | 32 | PC of the resolved jump |
| up_target | input | 32 | Resolved target address |

## Verification
The bench first fills one entry through thread 0. It then reaches the same entry from thread 0 with a PC adjusted for that thread's new history, and from thread 1 with the original PC. A design that shared one history among threads, or that indexed before shifting, would miss where a hit is due. A lookup and an update to the same entry in the same cycle must miss; a write-through design would wrongly hit. A PC with high bits set must alias to the low-bit entry, and a design that hashed more PC bits would fail to. Random traffic with a small PC pool and interleaved threads is compared against a bench model. That model catches a wrong shift amount, the wrong target bits folded in, and overwrites that land on the wrong entry.

// File: rtl/jtp_pkg.sv
package jtp_pkg;
  localparam int DEF_THREADS = 4;
  localparam int DEF_HIST_W  = 10;
  localparam int DEF_ADDR_W  = 32;
  // PC and target bits below this position are always zero (word aligned)
  localparam int WORD_LSB    = 2;
  // number of target bits folded into a history per resolved jump
  localparam int FOLD_W      = 2;
endpackage

// File: rtl/jtp_hist_bank.sv
module jtp_hist_bank #(
  parameter int THREADS = 4,
  parameter int HIST_W  = 10,
  parameter int FOLD_W  = 2,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       upd_en,
  input  logic [TID_W-1:0]           upd_tid,
  input  logic [FOLD_W-1:0]          upd_bits,
  input  logic [TID_W-1:0]           look_tid,
  output logic [HIST_W-1:0]          look_hist,
  output logic [HIST_W-1:0]          upd_hist,
  output logic [THREADS*HIST_W-1:0]  hist_flat
);
  logic [HIST_W-1:0] hist_q [THREADS];
  logic [HIST_W-1:0] hist_d [THREADS];
  logic [THREADS-1:0] hist_we;

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    always_comb begin
      hist_we[t] = upd_en && (upd_tid == TID_W'(t));
      hist_d[t]  = {hist_q[t][HIST_W-FOLD_W-1:0], {FOLD_W{1'b0}}}
                   ^ {{(HIST_W-FOLD_W){1'b0}}, upd_bits};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          hist_q[t] <= '0;
      else if (hist_we[t]) hist_q[t] <= hist_d[t];
    end

    assign hist_flat[t*HIST_W +: HIST_W] = hist_q[t];
  end

  assign look_hist = hist_q[look_tid];
  assign upd_hist  = hist_q[upd_tid];
endmodule

// File: rtl/jtp_target_table.sv
module jtp_target_table #(
  parameter int IDX_W   = 10,
  parameter int ADDR_W  = 32,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [IDX_W-1:0]   rd_idx,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ADDR_W-1:0]  wr_data,
  output logic               rd_vld,
  output logic [ADDR_W-1:0]  rd_data,
  output logic [ENTRIES-1:0] vld_vec
);
  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [ADDR_W-1:0]  mem_q [ENTRIES];
  logic               rd_vld_q, rd_vld_d;
  logic [ADDR_W-1:0]  rd_data_q;

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wr_idx] = 1'b1;
    rd_vld_d = rd_en && vld_q[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld_q  <= 1'b0;
      rd_data_q <= '0;
    end else begin
      rd_vld_q <= rd_vld_d;
      if (rd_en) rd_data_q <= mem_q[rd_idx];
    end
  end

  assign rd_vld  = rd_vld_q;
  assign rd_data = rd_data_q;
  assign vld_vec = vld_q;
endmodule

// File: rtl/jump_target_predictor.sv
module jump_target_predictor
  import jtp_pkg::*;
#(
  parameter int THREADS = DEF_THREADS,
  parameter int HIST_W  = DEF_HIST_W,
  parameter int ADDR_W  = DEF_ADDR_W,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int ENTRIES = 1 << HIST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_en,
  input  logic [TID_W-1:0]  lk_tid,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              pred_vld,
  output logic [ADDR_W-1:0] pred_target,
  input  logic              up_en,
  input  logic [TID_W-1:0]  up_tid,
  input  logic [ADDR_W-1:0] up_pc,
  input  logic [ADDR_W-1:0] up_target
);
  logic [HIST_W-1:0]         lk_hist, wr_hist;
  logic [HIST_W-1:0]         lk_idx, wr_idx;
  logic [THREADS*HIST_W-1:0] hist_flat;
  logic [ENTRIES-1:0]        tab_vld;

  jtp_hist_bank #(.THREADS(THREADS), .HIST_W(HIST_W), .FOLD_W(FOLD_W)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en    (up_en),
    .upd_tid   (up_tid),
    .upd_bits  (up_target[WORD_LSB +: FOLD_W]),
    .look_tid  (lk_tid),
    .look_hist (lk_hist),
    .upd_hist  (wr_hist),
    .hist_flat (hist_flat)
  );

  always_comb begin
    lk_idx = lk_pc[WORD_LSB +: HIST_W] ^ lk_hist;
    wr_idx = up_pc[WORD_LSB +: HIST_W] ^ wr_hist;
  end

  jtp_target_table #(.IDX_W(HIST_W), .ADDR_W(ADDR_W)) u_tab (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (lk_en),
    .rd_idx  (lk_idx),
    .wr_en   (up_en),
    .wr_idx  (wr_idx),
    .wr_data (up_target),
    .rd_vld  (pred_vld),
    .rd_data (pred_target),
    .vld_vec (tab_vld)
  );
endmodule

// File: rtl/jtp_checker.sv
module jtp_checker #(
  parameter int THREADS = 4,
  parameter int HIST_W  = 10,
  parameter int ADDR_W  = 32,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int ENTRIES = 1 << HIST_W
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      lk_en,
  input logic [HIST_W-1:0]         lk_idx,
  input logic                      up_en,
  input logic [TID_W-1:0]          up_tid,
  input logic [ADDR_W-1:0]         up_target,
  input logic [HIST_W-1:0]         wr_idx,
  input logic                      pred_vld,
  input logic [ENTRIES-1:0]        tab_vld,
  input logic [THREADS*HIST_W-1:0] hist_flat
);
  logic [HIST_W-1:0] cur_hist, exp_hist, pend_exp, pend_obs;
  logic [TID_W-1:0]  pend_tid;
  logic              pend;

  always_comb begin
    cur_hist = hist_flat[up_tid*HIST_W +: HIST_W];
    exp_hist = {cur_hist[HIST_W-3:0], 2'b00} ^ {{(HIST_W-2){1'b0}}, up_target[3:2]};
    pend_obs = hist_flat[pend_tid*HIST_W +: HIST_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      pend_tid <= '0;
      pend_exp <= '0;
    end else begin
      pend <= up_en;
      if (up_en) begin
        pend_tid <= up_tid;
        pend_exp <= exp_hist;
      end
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> !pred_vld);

  a_r2_idle_no_pred: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |=> !pred_vld);

  a_r4_invalid_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && !tab_vld[lk_idx] && !(up_en && wr_idx == lk_idx)) |=> !pred_vld);

  a_r4_written_valid: assert property (@(posedge clk) disable iff (!rst_n)
    up_en |=> tab_vld[$past(wr_idx)]);

  a_r5_hist_fold: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (pend_obs == pend_exp));

  for (genvar t = 0; t < THREADS; t++) begin : g_stab
    a_r6_other_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!up_en || up_tid != TID_W'(t)) |=> $stable(hist_flat[t*HIST_W +: HIST_W]));
  end
endmodule

bind jump_target_predictor jtp_checker #(
  .THREADS(THREADS), .HIST_W(HIST_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_en     (lk_en),
  .lk_idx    (lk_idx),
  .up_en     (up_en),
  .up_tid    (up_tid),
  .up_target (up_target),
  .wr_idx    (wr_idx),
  .pred_vld  (pred_vld),
  .tab_vld   (tab_vld),
  .hist_flat (hist_flat)
);

// File: tb/jump_target_predictor_test.sv
`timescale 1ns/1ps
module jump_target_predictor_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_en, up_en;
  logic [1:0]  lk_tid, up_tid;
  logic [31:0] lk_pc, up_pc, up_target;
  logic        pred_vld;
  logic [31:0] pred_target;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic        m_vld [1024];
  logic [31:0] m_tgt [1024];
  logic [9:0]  m_hist [4];

  always #2 clk = ~clk;

  jump_target_predictor uut (
    .clk(clk), .rst_n(rst_n),
    .lk_en(lk_en), .lk_tid(lk_tid), .lk_pc(lk_pc),
    .pred_vld(pred_vld), .pred_target(pred_target),
    .up_en(up_en), .up_tid(up_tid), .up_pc(up_pc), .up_target(up_target)
  );

  function automatic logic [9:0] f_idx(logic [31:0] pc, logic [9:0] h);
    return pc[11:2] ^ h;
  endfunction

  function automatic logic [9:0] f_fold(logic [9:0] h, logic [31:0] tgt);
    return {h[7:0], 2'b00} ^ {8'd0, tgt[3:2]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample 1 ns after the next rising edge
  task automatic step(string req, bit l, int lt, logic [31:0] lpc,
                      bit u, int ut, logic [31:0] upc, logic [31:0] utgt);
    logic [9:0]  li;
    logic        ev;
    logic [31:0] et;
    @(negedge clk);
    lk_en = l; lk_tid = 2'(lt); lk_pc = lpc;
    up_en = u; up_tid = 2'(ut); up_pc = upc; up_target = utgt;
    li = f_idx(lpc, m_hist[lt]);
    ev = l && m_vld[li];
    et = m_tgt[li];
    if (u) begin
      m_vld[f_idx(upc, m_hist[ut])] = 1'b1;
      m_tgt[f_idx(upc, m_hist[ut])] = utgt;
      m_hist[ut] = f_fold(m_hist[ut], utgt);
    end
    @(posedge clk); #1;
    chk({req, " vld"}, {31'd0, pred_vld}, {31'd0, ev});
    if (ev) chk({req, " target"}, pred_target, et);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < 1024; i++) begin m_vld[i] = 1'b0; m_tgt[i] = '0; end
    for (int t = 0; t < 4; t++) m_hist[t] = '0;
    rst_n = 1'b0; lk_en = 0; up_en = 0; lk_tid = 0; up_tid = 0;
    lk_pc = 0; up_pc = 0; up_target = 0;
    repeat (3) @(posedge clk);
    #1 chk("R1 in reset", {31'd0, pred_vld}, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    // R1: nothing valid after reset
    step("R1 miss", 1, 0, 32'h0000_0100, 0, 0, 0, 0);
    step("R1 miss", 1, 3, 32'h0000_0ffc, 0, 0, 0, 0);
    // R2: idle cycle
    step("R2 idle", 0, 0, 0, 0, 0, 0, 0);
    // fill entry 0x40 from thread 0 (history 0 -> 2)
    step("R2 fill", 0, 0, 0, 1, 0, 32'h0000_0100, 32'h0000_2348);
    // R3/R4: thread 0 reaches 0x40 with pc idx 0x42
    step("R4 hit", 1, 0, 32'h0000_0108, 0, 0, 0, 0);
    step("R3 shifted miss", 1, 0, 32'h0000_0100, 0, 0, 0, 0);
    // R6: thread 1 history untouched
    step("R6 hit", 1, 1, 32'h0000_0100, 0, 0, 0, 0);
    step("R6 miss", 1, 1, 32'h0000_0108, 0, 0, 0, 0);
    // R8: high PC bits ignored
    step("R8 alias", 1, 1, 32'hffff_f100, 0, 0, 0, 0);
    // R7: lookup and update of the same entry in one cycle
    step("R7 same cycle", 1, 2, 32'h0000_0200, 1, 2, 32'h0000_0200, 32'h0000_5554);
    // R5: thread 2 history now 1, so pc idx 0x81 reaches 0x80
    step("R5 fold", 1, 2, 32'h0000_0204, 0, 0, 0, 0);
    // R9: thread 3 overwrites entry 0x40
    step("R9 overwrite", 0, 0, 0, 1, 3, 32'h8000_0100, 32'hdead_bee0);
    step("R9 shared", 1, 1, 32'h0000_0100, 0, 0, 0, 0);
    step("R2 idle", 0, 0, 0, 0, 0, 0, 0);

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a, b, t;
      a = ($urandom & 32'hf000_0000) | (($urandom % 24) << 2);
      b = ($urandom & 32'hf000_0000) | (($urandom % 24) << 2);
      t = $urandom & 32'hffff_fffc;
      step("R4 random", ($urandom % 4) != 0, $urandom % 4, a,
           ($urandom % 2) != 0, $urandom % 4, b, t);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule